// File: doc/BRIEF.md
# Pipeline Slot Bottleneck Accounting Unit

This unit sits beside the allocation stage of a four-wide out-of-order core and accounts for where the core's issue capacity goes. On every clock in which the core is not halted it takes four slots of capacity and splits them among four buckets. The buckets are slots the front end failed to fill, slots the back end could not accept, slots whose uops retired, and slots lost to wrong speculation. Each bucket is a saturating counter. A total-slot counter sits beside them. Four cycle counters add detail: front-end latency, front-end bandwidth, execution-stall cycles and memory-bound stall cycles.

Empty slots are charged at allocation by a fixed priority. Recovery from a wrong speculation comes first, then a back end that is not ready, then a front end that is short of uops. Retired and squashed uops are counted when they are reported, so the buckets only sum exactly once in-flight uops have drained. The back-end bucket and the core-bound stall count are not stored. They are formed at read time as differences of stored counters. Software-side logic reads one counter at a time through a select input, and can freeze or clear the whole set.

Top module: `slot_bottleneck_acct`

## Requirements
- R1: On each clock with `unhalted` high and `freeze` low, the total-slot counter (select 0) grows by exactly 4.
- R2: In a counted cycle with `be_ready` high and `recovering` low, the front-end bucket (select 1) grows by 4 minus the offered count. The offered count is `fe_offered`, with values above 4 treated as 4.
- R3: The back-end bucket (select 2) reads as total minus front-end, retiring and bad-speculation buckets, and reads 0 if that difference is negative. A cycle with `be_ready` low never adds to the front-end bucket, even when the front end offered nothing.
- R4: In a counted cycle the retiring bucket (select 3) grows by `retire_cnt` and the bad-speculation bucket (select 4) grows by `squash_cnt`. Both inputs are clamped to 4.
- R5: In a counted cycle with `recovering` high, the bad-speculation bucket additionally grows by 4 minus `alloc_cnt` (clamped to 4). Nothing is charged to the front-end bucket or its cycle counters in that cycle.
- R6: With `be_ready` high and `recovering` low, a counted cycle adds one to front-end latency (select 5) when the offered count is 0. It adds one to front-end bandwidth (select 6) when the offered count is 1, 2 or 3.
- R7: A counted cycle with `exec_stall` high adds one to stall cycles (select 7). If `loads_pending` is also high, it adds one to memory-bound cycles (select 8). Core-bound cycles (select 9) read as stall cycles minus memory-bound cycles.
- R8: When `unhalted` is low or `freeze` is high, no counter changes.
- R9: A cycle with `clear` high zeroes every counter at the next edge, whatever the other inputs are.
- R10: Every stored counter stops at 2^CNT_W-1 instead of wrapping.
- R11: `rd_data` shows the counter picked by `rd_sel` in the same cycle. Codes 0 to 9 are as listed above, and codes 10 to 15 read 0. After reset, every code reads 0.
- R12: Once every allocated uop has retired or been squashed, the front-end, back-end, retiring and bad-speculation buckets sum exactly to the total-slot counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unhalted | input | 1 | Core is running this cycle |
| freeze | input | 1 | Hold all counters |
| clear | input | 1 | Zero all counters |
| fe_offered | input | 3 | Uops the front end offers this cycle (0 to 4) |
| be_ready | input | 1 | Back end can accept uops |
| alloc_cnt | input | 3 | Uops allocated this cycle |
| retire_cnt | input | 3 | Uops retired this cycle |
| squash_cnt | input | 3 | Uops cancelled by a flush this cycle |
| recovering | input | 1 | Machine is recovering from wrong speculation |
| exec_stall | input | 1 | Execution units stalled this cycle |
| loads_pending | input | 1 | At least one load is outstanding |
| rd_sel | input | 4 | Counter select |
| rd_data | output | CNT_W | Selected counter value |

## Verification
The bench aims at the priority corners of the slot split. A stall with both ends starved must not reach the front-end bucket, or the front-end share is inflated. A recovery cycle must charge its idle slots to bad speculation rather than to the front end. Freeze, halt and a clear that arrives together with counting activity are each tried directly. A design that drops the clear priority, or counts while frozen, shows a nonzero or shifted value. A narrow second instance runs long enough to saturate its counters, which would expose a counter that wraps. After a random run with a tracked in-flight population is drained, the four buckets are read and summed against the total. A mismatch there points to a slot that was charged twice or not at all.

// File: rtl/slot_bottleneck_acct.sv
module slot_bottleneck_acct #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unhalted,
  input  logic             freeze,
  input  logic             clear,
  input  logic [2:0]       fe_offered,
  input  logic             be_ready,
  input  logic [2:0]       alloc_cnt,
  input  logic [2:0]       retire_cnt,
  input  logic [2:0]       squash_cnt,
  input  logic             recovering,
  input  logic             exec_stall,
  input  logic             loads_pending,
  input  logic [3:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data
);
  localparam logic [3:0] SLOTS = 4'd4;
  localparam int DW = CNT_W + 2;

  function automatic logic [2:0] cap4(input logic [2:0] x);
    return (x > 3'd4) ? 3'd4 : x;
  endfunction

  function automatic logic [CNT_W-1:0] sadd(input logic [CNT_W-1:0] a, input logic [3:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {{(CNT_W-3){1'b0}}, b};
    return s[CNT_W] ? {CNT_W{1'b1}} : s[CNT_W-1:0];
  endfunction

  logic [CNT_W-1:0] tot_q, fe_q, ret_q, bad_q, lat_q, bw_q, exs_q, mem_q;

  wire       active  = unhalted & ~freeze;
  wire [2:0] off_c   = cap4(fe_offered);
  wire [2:0] alloc_c = cap4(alloc_cnt);
  wire       fe_ok   = be_ready & ~recovering;

  wire [3:0] fe_inc  = fe_ok ? (SLOTS - {1'b0, off_c}) : 4'd0;
  wire [3:0] ret_inc = {1'b0, cap4(retire_cnt)};
  wire [3:0] bad_inc = {1'b0, cap4(squash_cnt)} +
                       (recovering ? (SLOTS - {1'b0, alloc_c}) : 4'd0);
  wire       lat_hit = fe_ok & (off_c == 3'd0);
  wire       bw_hit  = fe_ok & (off_c != 3'd0) & (off_c != 3'd4);
  wire       mem_hit = exec_stall & loads_pending;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      tot_q <= '0; fe_q <= '0; ret_q <= '0; bad_q <= '0;
      lat_q <= '0; bw_q <= '0; exs_q <= '0; mem_q <= '0;
    end else if (active) begin
      tot_q <= sadd(tot_q, SLOTS);
      fe_q  <= sadd(fe_q, fe_inc);
      ret_q <= sadd(ret_q, ret_inc);
      bad_q <= sadd(bad_q, bad_inc);
      lat_q <= sadd(lat_q, {3'd0, lat_hit});
      bw_q  <= sadd(bw_q, {3'd0, bw_hit});
      exs_q <= sadd(exs_q, {3'd0, exec_stall});
      mem_q <= sadd(mem_q, {3'd0, mem_hit});
    end
  end

  logic [DW-1:0] be_raw;
  assign be_raw = {2'b0, tot_q} - {2'b0, fe_q} - {2'b0, ret_q} - {2'b0, bad_q};
  wire [CNT_W-1:0] be_val   = be_raw[DW-1] ? '0 : be_raw[CNT_W-1:0];
  wire [CNT_W-1:0] core_val = exs_q - mem_q;

  always_comb begin
    case (rd_sel)
      4'd0:    rd_data = tot_q;
      4'd1:    rd_data = fe_q;
      4'd2:    rd_data = be_val;
      4'd3:    rd_data = ret_q;
      4'd4:    rd_data = bad_q;
      4'd5:    rd_data = lat_q;
      4'd6:    rd_data = bw_q;
      4'd7:    rd_data = exs_q;
      4'd8:    rd_data = mem_q;
      4'd9:    rd_data = core_val;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/slot_bottleneck_chk.sv
module slot_bottleneck_chk #(
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             unhalted,
  input logic             freeze,
  input logic             clear,
  input logic             be_ready,
  input logic             recovering,
  input logic [CNT_W-1:0] tot_q,
  input logic [CNT_W-1:0] fe_q,
  input logic [CNT_W-1:0] exs_q,
  input logic [CNT_W-1:0] mem_q
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ROOM = TOP - 4;

  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (unhalted && !freeze && !clear && tot_q < ROOM) |=> tot_q == $past(tot_q) + 4); // R1

  AST_BE_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (!be_ready && !clear) |=> $stable(fe_q)); // R3

  AST_RECOVER_NO_FE: assert property (@(posedge clk) disable iff (!rst_n)
    (recovering && !clear) |=> $stable(fe_q)); // R5

  AST_MEM_WITHIN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_q <= exs_q); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((!unhalted || freeze) && !clear) |=> ($stable(tot_q) && $stable(exs_q))); // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (tot_q == '0 && fe_q == '0 && exs_q == '0 && mem_q == '0)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tot_q == TOP && !clear) |=> tot_q == TOP); // R10
endmodule

bind slot_bottleneck_acct slot_bottleneck_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .unhalted(unhalted), .freeze(freeze), .clear(clear),
  .be_ready(be_ready), .recovering(recovering),
  .tot_q(tot_q), .fe_q(fe_q), .exs_q(exs_q), .mem_q(mem_q)
);

// File: tb/slot_bottleneck_acct_test.sv
module slot_bottleneck_acct_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 48;
  localparam int SW = 6;
  localparam longint unsigned SMAX = (64'd1 << SW) - 1;

  logic clk = 0, rst_n = 0;
  logic unhalted = 0, freeze = 0, clear = 0, be_ready = 0, recovering = 0;
  logic exec_stall = 0, loads_pending = 0;
  logic [2:0] fe_offered = 0, alloc_cnt = 0, retire_cnt = 0, squash_cnt = 0;
  logic [3:0] rd_sel = 0, rd_sel_s = 0;
  logic [W-1:0] rd_data;
  logic [SW-1:0] rd_data_s;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_bottleneck_acct #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .unhalted(unhalted), .freeze(freeze), .clear(clear),
    .fe_offered(fe_offered), .be_ready(be_ready), .alloc_cnt(alloc_cnt),
    .retire_cnt(retire_cnt), .squash_cnt(squash_cnt), .recovering(recovering),
    .exec_stall(exec_stall), .loads_pending(loads_pending), .rd_sel(rd_sel), .rd_data(rd_data));

  slot_bottleneck_acct #(.CNT_W(SW)) sat_uut (
    .clk(clk), .rst_n(rst_n), .unhalted(unhalted), .freeze(freeze), .clear(clear),
    .fe_offered(fe_offered), .be_ready(be_ready), .alloc_cnt(alloc_cnt),
    .retire_cnt(retire_cnt), .squash_cnt(squash_cnt), .recovering(recovering),
    .exec_stall(exec_stall), .loads_pending(loads_pending), .rd_sel(rd_sel_s), .rd_data(rd_data_s));

  int checks = 0, errors = 0, cyc = 0;
  longint unsigned m_tot, m_fe, m_ret, m_bad, m_lat, m_bw, m_exs, m_mem;
  int inflight = 0;

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      report();
    end
  end

  function automatic longint unsigned cap(input logic [2:0] x);
    return (x > 3'd4) ? 4 : longint'(x);
  endfunction

  function automatic longint unsigned exp_of(input int s);
    longint signed d;
    case (s)
      0: return m_tot;
      1: return m_fe;
      2: begin d = longint'(m_tot) - longint'(m_fe) - longint'(m_ret) - longint'(m_bad);
               return (d < 0) ? 0 : longint'(d); end
      3: return m_ret;
      4: return m_bad;
      5: return m_lat;
      6: return m_bw;
      7: return m_exs;
      8: return m_mem;
      9: return m_exs - m_mem;
      default: return 0;
    endcase
  endfunction

  function automatic longint unsigned smin(input longint unsigned v);
    return (v > SMAX) ? SMAX : v;
  endfunction

  task automatic chk(input string tag, input string what, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int s = 0; s < 11; s++) begin
      rd_sel = (s == 10) ? 4'd15 : 4'(s);
      #1;
      chk(tag, $sformatf("select %0d", rd_sel), longint'(rd_data), exp_of((s == 10) ? 15 : s));
    end
  endtask

  task automatic model_zero();
    m_tot = 0; m_fe = 0; m_ret = 0; m_bad = 0; m_lat = 0; m_bw = 0; m_exs = 0; m_mem = 0;
  endtask

  task automatic step(input logic u, input logic fz, input logic cl, input logic br, input logic rc,
                      input logic es, input logic lp, input logic [2:0] off, input logic [2:0] al,
                      input logic [2:0] rt, input logic [2:0] sq);
    longint unsigned o;
    @(negedge clk);
    unhalted = u; freeze = fz; clear = cl; be_ready = br; recovering = rc;
    exec_stall = es; loads_pending = lp; fe_offered = off; alloc_cnt = al;
    retire_cnt = rt; squash_cnt = sq;
    @(posedge clk); #1;
    unhalted = 0; freeze = 0; clear = 0;
    if (cl) model_zero();
    else if (u && !fz) begin
      o = cap(off);
      m_tot += 4;
      if (br && !rc) begin
        m_fe += 4 - o;
        if (o == 0) m_lat++;
        else if (o != 4) m_bw++;
      end
      m_ret += cap(rt);
      m_bad += cap(sq) + (rc ? 4 - cap(al) : 0);
      if (es) m_exs++;
      if (es && lp) m_mem++;
    end
  endtask

  initial begin
    logic br, rc, u, fz;
    logic [2:0] off, al, rt, sq;
    longint unsigned a0, a1, a2, a3, a4;
    model_zero();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_all("R11 reset");

    step(1,0,0,1,0,0,0,3'd1,3'd1,0,0);  check_all("R2 R6 one offered");
    step(1,0,0,1,0,0,0,3'd0,3'd0,0,0);  check_all("R6 latency");
    step(1,0,0,1,0,0,0,3'd7,3'd4,0,0);  check_all("R2 offered clamp");
    step(1,0,0,0,0,0,0,3'd0,3'd0,0,0);  check_all("R3 back-end priority");
    step(1,0,0,1,1,0,0,3'd0,3'd1,0,0);  check_all("R5 recovery");
    step(1,0,0,0,0,1,1,3'd0,3'd0,3'd1,3'd2); check_all("R4 R7 memory stall");
    step(1,0,0,0,0,1,0,3'd0,3'd0,3'd4,0); check_all("R7 core stall");
    step(1,1,0,1,0,1,1,3'd0,3'd0,3'd3,3'd3); check_all("R8 freeze");
    step(0,0,0,1,1,1,1,3'd0,3'd0,3'd3,3'd3); check_all("R8 halted");
    step(1,0,1,1,0,1,1,3'd0,3'd0,3'd3,3'd3); check_all("R9 clear while counting");
    inflight = 0;

    for (int i = 0; i < 3000; i++) begin
      u  = ($urandom % 8) != 0;
      fz = ($urandom % 32) == 0;
      rc = ($urandom % 16) == 0;
      br = ($urandom % 4) != 0;
      off = 3'($urandom % 5);
      al = (br && !rc) ? off : 3'd0;
      rt = 3'(($urandom % 5 < inflight) ? $urandom % 5 : inflight);
      sq = 0;
      if (($urandom % 20) == 0 && (inflight - int'(rt)) > 0)
        sq = 3'((inflight - int'(rt) > 4) ? 4 : inflight - int'(rt));
      if (!(u && !fz)) begin al = 0; rt = 0; sq = 0; end
      inflight = inflight - int'(rt) - int'(sq);
      step(u, fz, 0, br, rc, ($urandom % 3) == 0, $urandom % 2, off, al, rt, sq);
      inflight += int'(al);
      if (i % 250 == 249) check_all("R1 R4 random");
    end

    while (inflight > 0) begin
      rt = 3'((inflight > 4) ? 4 : inflight);
      inflight -= int'(rt);
      step(1,0,0,0,0,0,0,3'd0,3'd0,rt,3'd0);
    end
    check_all("R12 drained");
    rd_sel = 0; #1; a0 = longint'(rd_data);
    rd_sel = 1; #1; a1 = longint'(rd_data);
    rd_sel = 2; #1; a2 = longint'(rd_data);
    rd_sel = 3; #1; a3 = longint'(rd_data);
    rd_sel = 4; #1; a4 = longint'(rd_data);
    chk("R12", "bucket sum", a1 + a2 + a3 + a4, a0);

    for (int s = 0; s < 9; s++) begin
      if (s == 2) continue;
      rd_sel_s = 4'(s); #1;
      chk("R10", $sformatf("narrow select %0d", s), longint'(rd_data_s), smin(exp_of(s)));
    end

    step(1,0,1,0,0,0,0,3'd0,3'd0,0,0);
    check_all("R9 final clear");
    rd_sel_s = 0; #1;
    chk("R9", "narrow total", longint'(rd_data_s), 0);
    report();
  end
endmodule